// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a translation miss by descending a four-level radix page table in memory. A miss request gives it a virtual page number and the physical base address of the root table. The walker then issues one memory read per level, through a valid/ready request channel and a valid-only response channel. Every read address is built from the current table base and a nine-bit slice of the page number. The entry that comes back supplies the base of the next table.

A walk ends in one of two ways. The leaf entry can be present, in which case its frame number and attribute bits are offered to the translation buffer for refill. Or an entry at some level can be non-present, in which case a fault is raised that carries the number of that level. The result is held until the buffer acknowledges it. Only one walk is in flight at a time. While a walk runs, `busy` is high and any new miss request is refused.

Top module: `ptw_walker`

## Requirements
- R1: During and after reset, `busy`, `mem_req_valid`, `fill_valid` and `fault_valid` are low.
- R2: A request with `req_valid` high while `busy` is low is accepted at that clock edge, and `busy` is high from the next cycle.
- R3: A request presented while `busy` is high is ignored: it causes no read, and it does not change the result of the walk in progress.
- R4: Reads visit the levels in a fixed order, top first. The index is `req_vpn[35:27]` for level 0, then `[26:18]` for level 1, `[17:9]` for level 2 and `[8:0]` for level 3.
- R5: Each read address is the table base plus the index times 8. The level-0 base is `req_base`. Each later base is bits [39:12] of the entry just read, followed by twelve zero bits.
- R6: At most one read is outstanding. After a request handshake, `mem_req_valid` stays low until the response arrives, and a walk makes exactly one read per level it reaches.
- R7: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and `mem_req_addr` does not change.
- R8: The present flag is entry bit 0. An entry with bit 0 clear ends the walk: `fault_valid` rises with `fault_level` set to that level (0 for the top, 3 for the leaf), no further read is made, and `fill_valid` stays low.
- R9: A present leaf gives `fill_valid` high, `fill_vpn` equal to the walked page number, `fill_pfn` equal to leaf bits [39:12], and `fill_attr` equal to `{leaf[63:40], leaf[11:1]}`.
- R10: A result stays valid and stable until `done_ready` is high at a clock edge. After that edge, `busy`, `fill_valid` and `fault_valid` are low.
- R11: `fill_valid` and `fault_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request strobe |
| req_vpn | input | 36 | Virtual page number to translate |
| req_base | input | 40 | Physical base of the root table |
| busy | output | 1 | A walk is in progress; requests are refused |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 40 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| fill_valid | output | 1 | Refill result valid |
| fill_vpn | output | 36 | Page number of the refill |
| fill_pfn | output | 28 | Frame number of the refill |
| fill_attr | output | 35 | Leaf attribute bits {63:40, 11:1} |
| fault_valid | output | 1 | Walk ended on a non-present entry |
| fault_level | output | 2 | Level of the non-present entry |
| done_ready | input | 1 | Acknowledges the current result |

## Verification
The first read request appears in the cycle after the request is accepted. Each later request appears in the cycle after the previous response. The result appears in the cycle after the last response, and `busy` falls in the cycle after the `done_ready` edge. The bench drives every input on the falling edge and samples on the next falling edge, so each check reads the value one register stage past the edge that causes it. The behavioural memory checks every read address at the moment of its handshake against an address list that the reference walk predicts. It stalls handshakes at random and adds a random response delay, so the walk's timing differs from run to run. `busy` is compared against the bench's own model on every cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } walk_state_t;
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  localparam int VPN_W = LEVELS * IDX_W,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] level,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] slices [LEVELS];

  // level 0 takes the most significant slice
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign slices[g] = vpn[VPN_W-1-g*IDX_W -: IDX_W];
  end

  assign idx = slices[level];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PA_W        = 40,
  parameter int IDX_W       = 9,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic [PA_W-1:0]  base,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  addr
);
  assign addr = base + (PA_W'(idx) << ENTRY_SHIFT);
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int PTE_W      = 64,
  parameter int PA_W       = 40,
  parameter int PAGE_SHIFT = 12,
  localparam int PFN_W  = PA_W - PAGE_SHIFT,
  localparam int ATTR_W = (PTE_W - PA_W) + (PAGE_SHIFT - 1)
) (
  input  logic [PTE_W-1:0]  pte,
  output logic              present,
  output logic [PFN_W-1:0]  frame,
  output logic [ATTR_W-1:0] attr
);
  assign present = pte[0];
  assign frame   = pte[PA_W-1:PAGE_SHIFT];
  assign attr    = {pte[PTE_W-1:PA_W], pte[PAGE_SHIFT-1:1]};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int LEVELS      = 4,
  parameter int IDX_W       = 9,
  parameter int PA_W        = 40,
  parameter int PTE_W       = 64,
  parameter int PAGE_SHIFT  = 12,
  parameter int ENTRY_SHIFT = 3,
  localparam int VPN_W  = LEVELS * IDX_W,
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int PFN_W  = PA_W - PAGE_SHIFT,
  localparam int ATTR_W = (PTE_W - PA_W) + (PAGE_SHIFT - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [PA_W-1:0]   req_base,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              fill_valid,
  output logic [VPN_W-1:0]  fill_vpn,
  output logic [PFN_W-1:0]  fill_pfn,
  output logic [ATTR_W-1:0] fill_attr,
  output logic              fault_valid,
  output logic [LVL_W-1:0]  fault_level,
  input  logic              done_ready
);
  import ptw_pkg::*;

  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walk_state_t       state_q;
  logic [LVL_W-1:0]  level_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [PA_W-1:0]   addr_q;

  logic              idle;
  logic [VPN_W-1:0]  sel_vpn;
  logic [LVL_W-1:0]  sel_level;
  logic [PA_W-1:0]   sel_base;
  logic [IDX_W-1:0]  sel_idx;
  logic [PA_W-1:0]   next_addr;
  logic              rsp_present;
  logic [PFN_W-1:0]  rsp_frame;
  logic [ATTR_W-1:0] rsp_attr;

  assign idle = (state_q == ST_IDLE);

  // One shared index/address path: the root on accept, the next level after a response
  assign sel_vpn   = idle ? req_vpn : vpn_q;
  assign sel_level = idle ? '0 : level_q + LVL_W'(1);
  assign sel_base  = idle ? req_base : {rsp_frame, {PAGE_SHIFT{1'b0}}};

  ptw_index_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W)) u_idx (
    .vpn(sel_vpn), .level(sel_level), .idx(sel_idx)
  );

  ptw_addr_gen #(.PA_W(PA_W), .IDX_W(IDX_W), .ENTRY_SHIFT(ENTRY_SHIFT)) u_addr (
    .base(sel_base), .idx(sel_idx), .addr(next_addr)
  );

  ptw_pte_decode #(.PTE_W(PTE_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_dec (
    .pte(mem_rsp_data), .present(rsp_present), .frame(rsp_frame), .attr(rsp_attr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      level_q     <= '0;
      vpn_q       <= '0;
      addr_q      <= '0;
      fill_valid  <= 1'b0;
      fill_pfn    <= '0;
      fill_attr   <= '0;
      fault_valid <= 1'b0;
      fault_level <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vpn_q   <= req_vpn;
            level_q <= '0;
            addr_q  <= next_addr;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (!rsp_present) begin
              fault_valid <= 1'b1;
              fault_level <= level_q;
              state_q     <= ST_DONE;
            end else if (level_q == LAST_LVL) begin
              fill_valid <= 1'b1;
              fill_pfn   <= rsp_frame;
              fill_attr  <= rsp_attr;
              state_q    <= ST_DONE;
            end else begin
              level_q <= level_q + LVL_W'(1);
              addr_q  <= next_addr;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_DONE: begin
          if (done_ready) begin
            fill_valid  <= 1'b0;
            fault_valid <= 1'b0;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = !idle;
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_req_addr  = addr_q;
  assign fill_vpn      = vpn_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PA_W  = 40,
  parameter int PFN_W = 28,
  parameter int LVL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             busy,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             fill_valid,
  input logic [PFN_W-1:0] fill_pfn,
  input logic             fault_valid,
  input logic [LVL_W-1:0] fault_level,
  input logic             done_ready
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req_valid && !fill_valid && !fault_valid)); // R1

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy); // R2

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R6

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R7

  AST_NO_READ_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    (fill_valid || fault_valid) |-> !mem_req_valid); // R8

  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !done_ready) |=> (fill_valid && $stable(fill_pfn))); // R10

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fault_valid && !done_ready) |=> (fault_valid && $stable(fault_level))); // R10

  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fill_valid && fault_valid)); // R11
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W), .PFN_W(PFN_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .fill_valid(fill_valid), .fill_pfn(fill_pfn),
  .fault_valid(fault_valid), .fault_level(fault_level), .done_ready(done_ready)
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
  localparam int LEVELS = 4;
  localparam int IDX_W  = 9;
  localparam int PA_W   = 40;
  localparam int PTE_W  = 64;
  localparam int VPN_W  = 36;
  localparam int PFN_W  = 28;
  localparam int ATTR_W = 35;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic              req_valid = 1'b0;
  logic [VPN_W-1:0]  req_vpn = '0;
  logic [PA_W-1:0]   req_base = '0;
  logic              busy;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic [PA_W-1:0]   mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [PTE_W-1:0]  mem_rsp_data = '0;
  logic              fill_valid;
  logic [VPN_W-1:0]  fill_vpn;
  logic [PFN_W-1:0]  fill_pfn;
  logic [ATTR_W-1:0] fill_attr;
  logic              fault_valid;
  logic [1:0]        fault_level;
  logic              done_ready = 1'b0;

  ptw_walker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vpn(req_vpn), .req_base(req_base),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_attr(fill_attr),
    .fault_valid(fault_valid), .fault_level(fault_level), .done_ready(done_ready)
  );

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;
  bit  model_busy = 0;
  logic [PTE_W-1:0] mem [logic [PA_W-1:0]];
  logic [PA_W-1:0]  exp_q [$];
  logic [PA_W-1:0]  next_tbl = 40'h00_0010_0000;

  task automatic check_eq(input string req, input string what, input logic [63:0] act,
                          input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [PTE_W-1:0] rd(input logic [PA_W-1:0] a);
    return mem.exists(a) ? mem[a] : '0;
  endfunction

  function automatic logic [IDX_W-1:0] slice(input logic [VPN_W-1:0] v, input int lvl);
    return IDX_W'(v >> (IDX_W * (LEVELS - 1 - lvl)));
  endfunction

  // Map a page; depth < LEVELS plants a non-present entry at that level
  task automatic build(input logic [PA_W-1:0] root, input logic [VPN_W-1:0] v, input int depth,
                       input logic [PFN_W-1:0] pfn, input logic [ATTR_W-1:0] attr);
    logic [PA_W-1:0]  tbase = root;
    logic [PA_W-1:0]  a;
    logic [PTE_W-1:0] e;
    for (int l = 0; l < LEVELS; l++) begin
      a = tbase + PA_W'(slice(v, l)) * 8;
      if (l == depth) begin
        mem[a] = {24'hABCDEF, 28'h5A5A5A5, 11'h7FF, 1'b0};
        return;
      end
      if (l == LEVELS - 1) begin
        mem[a] = {attr[34:11], pfn, attr[10:0], 1'b1};
      end else begin
        e = rd(a);
        if (!e[0]) begin
          mem[a] = {24'h0, next_tbl[PA_W-1:12], 11'h0, 1'b1};
          next_tbl += 40'h1000;
        end
        e = rd(a);
        tbase = {e[PA_W-1:12], 12'h0};
      end
    end
  endtask

  // Reference walk: predicts every read address and the outcome
  task automatic ref_walk(input logic [PA_W-1:0] root, input logic [VPN_W-1:0] v,
                          output bit is_fault, output int flvl,
                          output logic [PFN_W-1:0] pfn, output logic [ATTR_W-1:0] attr);
    logic [PA_W-1:0]  tbase = root;
    logic [PA_W-1:0]  a;
    logic [PTE_W-1:0] e;
    is_fault = 0; flvl = 0; pfn = '0; attr = '0;
    for (int l = 0; l < LEVELS; l++) begin
      a = tbase + PA_W'(slice(v, l)) * 8;
      exp_q.push_back(a);
      e = rd(a);
      if (!e[0]) begin
        is_fault = 1; flvl = l;
        return;
      end
      if (l == LEVELS - 1) begin
        pfn  = e[PA_W-1:12];
        attr = {e[63:40], e[11:1]};
      end else begin
        tbase = {e[PA_W-1:12], 12'h0};
      end
    end
  endtask

  // Every cycle: busy compared against the model
  task automatic tick();
    @(negedge clk);
    check_eq("R2 R10", "busy vs model", 64'(busy), 64'(model_busy));
  endtask

  // Behavioural memory: random ready, random response delay, address check at handshake
  initial begin
    bit pending = 0;
    int lat = 0;
    logic [PA_W-1:0] paddr = '0;
    logic [PA_W-1:0] e;
    forever begin
      @(negedge clk);
      if (pending) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(paddr);
          pending = 0;
        end else begin
          lat--;
          mem_rsp_valid = 1'b0;
        end
      end else begin
        mem_rsp_valid = 1'b0;
      end
      mem_req_ready = (($urandom % 3) != 0);
      if (!rst && mem_req_valid && mem_req_ready) begin
        pending = 1;
        lat = int'($urandom % 4);
        paddr = mem_req_addr;
        if (exp_q.size() == 0) begin
          check_eq("R6", "unexpected extra read", 64'(mem_req_addr), 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
          e = exp_q.pop_front();
          check_eq("R4 R5", "read address", 64'(mem_req_addr), 64'(e));
        end
      end
    end
  end

  task automatic do_walk(input logic [PA_W-1:0] root, input logic [VPN_W-1:0] v,
                         input int ack_wait, input bit poke);
    bit is_fault;
    int flvl;
    int cyc = 0;
    logic [PFN_W-1:0]  pfn;
    logic [ATTR_W-1:0] attr;
    ref_walk(root, v, is_fault, flvl, pfn, attr);
    req_vpn = v; req_base = root; req_valid = 1'b1;
    model_busy = 1;
    tick();
    req_valid = 1'b0;
    while (!(fill_valid || fault_valid) && cyc < 400) begin
      if (poke && cyc == 2) begin
        // R3: request during a walk must be refused
        req_valid = 1'b1; req_vpn = ~v; req_base = root + 40'h3000;
      end else begin
        req_valid = 1'b0;
      end
      tick();
      cyc++;
    end
    req_valid = 1'b0;
    check_eq("R6 R8", "reads left unmade", 64'(exp_q.size()), 64'd0);
    check_eq("R8", "fault_valid", 64'(fault_valid), 64'(is_fault));
    check_eq("R11", "fill_valid", 64'(fill_valid), 64'(!is_fault));
    if (is_fault) begin
      check_eq("R8", "fault_level", 64'(fault_level), 64'(flvl));
    end else begin
      check_eq("R9", "fill_vpn", 64'(fill_vpn), 64'(v));
      check_eq("R9", "fill_pfn", 64'(fill_pfn), 64'(pfn));
      check_eq("R9", "fill_attr", 64'(fill_attr), 64'(attr));
      if (poke) check_eq("R3", "pfn after refused request", 64'(fill_pfn), 64'(pfn));
    end
    for (int i = 0; i < ack_wait; i++) begin
      tick();
      check_eq("R10", "result held", 64'(fill_valid || fault_valid), 64'd1);
      if (!is_fault) check_eq("R10", "pfn stable", 64'(fill_pfn), 64'(pfn));
    end
    done_ready = 1'b1;
    model_busy = 0;
    tick();
    done_ready = 1'b0;
    check_eq("R10", "fill_valid after ack", 64'(fill_valid), 64'd0);
    check_eq("R10", "fault_valid after ack", 64'(fault_valid), 64'd0);
    tick();
    check_eq("R3", "no read after walk", 64'(mem_req_valid), 64'd0);
  endtask

  localparam logic [PA_W-1:0] ROOT_A = 40'h00_0001_0000;
  localparam logic [PA_W-1:0] ROOT_B = 40'h00_0008_0000;

  initial begin
    rst = 1'b1;
    model_busy = 0;
    for (int i = 0; i < 4; i++) @(negedge clk);
    check_eq("R1", "busy in reset", 64'(busy), 64'd0);
    check_eq("R1", "mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
    check_eq("R1", "fill_valid in reset", 64'(fill_valid), 64'd0);
    check_eq("R1", "fault_valid in reset", 64'(fault_valid), 64'd0);
    rst = 1'b0;
    tick();
    check_eq("R1", "busy after reset", 64'(busy), 64'd0);

    build(ROOT_A, 36'h0_1234_5678, 4, 28'h00ABCDE, 35'h4_0000_05A3);
    build(ROOT_A, 36'h3_0000_01FF, 4, 28'h1234567, 35'h0_0000_0003);
    build(ROOT_A, 36'h0_1237_0001, 4, 28'hFEDCBA9, 35'h7_FFFF_FFFF);
    build(ROOT_A, 36'h9_0000_0000, 1, '0, '0);
    build(ROOT_A, 36'hA_0000_0000, 2, '0, '0);
    build(ROOT_A, 36'hB_0000_0000, 3, '0, '0);
    build(ROOT_A, 36'hF_FFFF_FFFF, 4, 28'h0000001, 35'h0_0000_0001);
    build(ROOT_A, 36'h0_0000_0000, 4, 28'h8000000, 35'h0_0000_0400);
    build(ROOT_B, 36'h0_1234_5678, 4, 28'h0C0FFEE, 35'h1_0000_0002);

    do_walk(ROOT_A, 36'h0_1234_5678, 0, 0);   // R4 R5 R9 full walk
    do_walk(ROOT_A, 36'h3_0000_01FF, 3, 0);   // R10 delayed ack
    do_walk(ROOT_A, 36'h0_1237_0001, 1, 0);   // shared upper tables
    do_walk(ROOT_A, 36'h8_0000_0000, 2, 0);   // R8 fault at level 0
    do_walk(ROOT_A, 36'h9_0000_0000, 0, 0);   // R8 fault at level 1
    do_walk(ROOT_A, 36'hA_0000_0000, 1, 0);   // R8 fault at level 2
    do_walk(ROOT_A, 36'hB_0000_0000, 0, 0);   // R8 fault at leaf
    do_walk(ROOT_A, 36'hF_FFFF_FFFF, 0, 0);   // all-ones slices
    do_walk(ROOT_A, 36'h0_0000_0000, 0, 0);   // all-zero slices
    do_walk(ROOT_A, 36'h0_1234_5678, 2, 1);   // R3 refused request mid-walk
    do_walk(ROOT_B, 36'h0_1234_5678, 0, 0);   // R5 other root base
    do_walk(ROOT_A, 36'h9_0000_0000, 0, 1);   // R3 during a faulting walk

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule